// File: doc/BRIEF.md
# Serial-Frame Power-Mode Sequencer

This block is the power-management controller for a converter with a serial interface. It watches the frame select (active low), the serial clock and the serial data line. All three are brought into the system clock domain. The block counts rising serial-clock edges inside each frame. From the first fifteen bits of the frame it captures two power-mode bits and a reference-enable bit. From these it drives four things: core power-down, reference power-down, the track/hold setting and a ready flag.

Two automatic low-power modes exist. Automatic shutdown turns off everything, the reference included. Automatic standby turns off the core, and keeps the reference on when the frame's reference-enable bit is 1. Either mode is entered on the 15th rising serial-clock edge of a frame. It is left when the frame select rises, which starts a wake-up interval. The length of that interval depends on the mode and is set by a parameter in system-clock cycles. The block reports ready only after the interval has run out. Every frame is classed as valid or invalid by whether the block was ready when the frame began.

Top module: `frame_pwr_sequencer`

States:
- `PS_READY`: powered and ready.
- `PS_DOWN`: low power, track/hold held.
- `PS_WAKE`: powering up, track/hold tracking.

Transitions:
- READY→DOWN and WAKE→DOWN: taken when a frame completes its 15th edge carrying an automatic mode.
- DOWN→WAKE: taken on a frame-select rising edge.
- WAKE→READY: taken when the wake timer expires.

## Requirements
- R1: While reset is asserted and right after it is released, the outputs are `ready`=1, `core_off`=0, `ref_off`=0, `hold_mode`=0 and `frame_invalid`=0.
- R2: A frame begins on a falling edge of `cs_n`, and that edge clears the edge count.
    - Captured word bit p is the `sdin` value at the (15-p)th rising `sclk` edge of the frame. Mode bits are word bits [5:4]; reference enable is word bit 3.
    - Edges after the 15th are ignored.
    - A frame that ends before its 15th edge changes nothing.
- R3: The 15th edge powers the block down (`core_off`=1, `ready`=0) when mode bits are 2'b10 (shutdown) or 2'b01 (standby).
- R4: While powered down, `ref_off` is 1 in shutdown. In standby it is the inverse of the captured reference-enable bit. `ref_off` is never 1 while `core_off` is 0.
- R5: Mode codes 2'b00 and 2'b11 mean normal operation. They power nothing down, and a frame carrying them does not interrupt a wake interval in progress.
- R6: The powered-down state, with `hold_mode`=1, persists until a rising edge of `cs_n`. That edge clears `core_off`, `ref_off` and `hold_mode` and starts the wake interval.
- R7: `ready` returns exactly SHDN_WAKE_CYC cycles after the wake interval starts when leaving shutdown, or STBY_WAKE_CYC cycles when leaving standby. It is never 1 while `core_off` or `hold_mode` is 1.
- R8: At each falling edge of `cs_n`, `frame_invalid` is loaded with 1 if `ready` was 0, and with 0 otherwise.
- R9: A frame that reaches its 15th edge during the wake interval with an automatic mode code powers the block down again.
- R10: An edge on a pin shows at the outputs on the third rising clock edge after the pin changes, because of the two synchroniser stages plus the state register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Frame select, active low |
| sclk | input | 1 | Serial clock, idle low |
| sdin | input | 1 | Serial data in, MSB first |
| core_off | output | 1 | Core power-down |
| ref_off | output | 1 | Reference power-down |
| hold_mode | output | 1 | 1 = track/hold in hold |
| ready | output | 1 | Fully powered and ready |
| frame_invalid | output | 1 | Last frame began before ready |

## Verification
The bound checker watches the relations between outputs on every cycle:
- hold always accompanies core power-down;
- the reference is only off when the core is off;
- ready excludes both core-off and hold;
- ready can only rise out of a powered-up, not-ready cycle, so it never rises directly from the powered-down state.

The bench's scenarios are the only means of showing the rest, which depends on whole frames:
- which bit positions carry the mode;
- that aborted frames and extra edges have no effect;
- the exact wake-interval lengths;
- the three-cycle pin latency;
- the invalid-frame flag for frames started while waking.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    typedef enum logic [1:0] {
        PS_READY = 2'd0,
        PS_DOWN  = 2'd1,
        PS_WAKE  = 2'd2
    } pwr_state_t;

    typedef enum logic [1:0] {
        LP_NONE     = 2'd0,
        LP_SHUTDOWN = 2'd1,
        LP_STANDBY  = 2'd2
    } lp_kind_t;

    // Power-mode field decode: {hi, lo}
    function automatic lp_kind_t decode_mode(input logic [1:0] bits);
        lp_kind_t k;
        unique case (bits)
            2'b10:   k = LP_SHUTDOWN;
            2'b01:   k = LP_STANDBY;
            default: k = LP_NONE;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/pwrseq_sync.sv
module pwrseq_sync #(
    parameter int          W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] q_prev
);

    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
            q_prev <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
            q_prev <= q;
        end
    end

endmodule

// File: rtl/pwrseq_frame.sv
module pwrseq_frame
    import pwrseq_pkg::*;
#(
    parameter int WORD_W    = 15,
    parameter int MODE_POS  = 4,
    parameter int REFEN_POS = 3
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cs_fall,
    input  logic     cs_low,
    input  logic     sclk_rise,
    input  logic     sdin_s,
    output logic     word_done,
    output lp_kind_t word_kind,
    output logic     word_ref_en
);

    localparam int CNT_W  = $clog2(WORD_W + 1);
    localparam int N_FLD  = 3;
    localparam int FPOS [N_FLD] = '{REFEN_POS, MODE_POS, MODE_POS + 1};

    logic [CNT_W-1:0] edge_cnt;
    logic             take_edge;
    logic [N_FLD-1:0] fld_now;

    assign take_edge = sclk_rise && cs_low && !cs_fall
                       && (edge_cnt < CNT_W'(WORD_W));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_cnt <= '0;
        end else if (cs_fall) begin
            edge_cnt <= '0;
        end else if (take_edge) begin
            edge_cnt <= edge_cnt + 1'b1;
        end
    end

    // One capture slot per field; a field in bit 0 arrives on the last edge
    for (genvar g = 0; g < N_FLD; g++) begin : g_fld
        localparam int P = FPOS[g];
        if (P == 0) begin : g_live
            assign fld_now[g] = sdin_s;
        end else begin : g_reg
            logic bit_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    bit_q <= 1'b0;
                end else if (take_edge && edge_cnt == CNT_W'(WORD_W - 1 - P)) begin
                    bit_q <= sdin_s;
                end
            end
            assign fld_now[g] = bit_q;
        end
    end

    assign word_done   = take_edge && (edge_cnt == CNT_W'(WORD_W - 1));
    assign word_kind   = decode_mode(fld_now[2:1]);
    assign word_ref_en = fld_now[0];

endmodule

// File: rtl/pwrseq_timer.sv
module pwrseq_timer
    import pwrseq_pkg::*;
#(
    parameter int SHDN_WAKE_CYC = 25000,
    parameter int STBY_WAKE_CYC = 38
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load,
    input  lp_kind_t kind,
    input  logic     run,
    output logic     expired
);

    localparam int MAX_CYC = (SHDN_WAKE_CYC > STBY_WAKE_CYC) ? SHDN_WAKE_CYC : STBY_WAKE_CYC;
    localparam int TW      = $clog2(MAX_CYC + 1);

    logic [TW-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= (kind == LP_SHUTDOWN) ? TW'(SHDN_WAKE_CYC - 1)
                                            : TW'(STBY_WAKE_CYC - 1);
        end else if (run && remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign expired = (remain == '0);

endmodule

// File: rtl/frame_pwr_sequencer.sv
module frame_pwr_sequencer
    import pwrseq_pkg::*;
#(
    parameter int WORD_W        = 15,
    parameter int MODE_POS      = 4,
    parameter int REFEN_POS     = 3,
    parameter int SHDN_WAKE_CYC = 25000,
    parameter int STBY_WAKE_CYC = 38
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic sdin,
    output logic core_off,
    output logic ref_off,
    output logic hold_mode,
    output logic ready,
    output logic frame_invalid
);

    // pin order inside the synchroniser: {cs_n, sclk, sdin}
    localparam int IDX_CS = 2;
    localparam int IDX_SC = 1;
    localparam int IDX_SD = 0;

    logic [2:0] pin_q, pin_prev;
    logic       cs_fall, cs_rise, cs_low, sclk_rise;
    logic       word_done, word_ref_en, tmr_expired, tmr_load;
    lp_kind_t   word_kind, lp_q;
    logic       refen_q;
    pwr_state_t state_q, state_d;

    pwrseq_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d      ({cs_n, sclk, sdin}),
        .q      (pin_q),
        .q_prev (pin_prev)
    );

    assign cs_low    = !pin_q[IDX_CS];
    assign cs_fall   = !pin_q[IDX_CS] &&  pin_prev[IDX_CS];
    assign cs_rise   =  pin_q[IDX_CS] && !pin_prev[IDX_CS];
    assign sclk_rise =  pin_q[IDX_SC] && !pin_prev[IDX_SC];

    pwrseq_frame #(
        .WORD_W    (WORD_W),
        .MODE_POS  (MODE_POS),
        .REFEN_POS (REFEN_POS)
    ) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_fall     (cs_fall),
        .cs_low      (cs_low),
        .sclk_rise   (sclk_rise),
        .sdin_s      (pin_q[IDX_SD]),
        .word_done   (word_done),
        .word_kind   (word_kind),
        .word_ref_en (word_ref_en)
    );

    assign tmr_load = (state_q == PS_DOWN) && cs_rise;

    pwrseq_timer #(
        .SHDN_WAKE_CYC (SHDN_WAKE_CYC),
        .STBY_WAKE_CYC (STBY_WAKE_CYC)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .kind    (lp_q),
        .run     (state_q == PS_WAKE),
        .expired (tmr_expired)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_READY: if (word_done && word_kind != LP_NONE) state_d = PS_DOWN;
            PS_DOWN:  if (cs_rise)                           state_d = PS_WAKE;
            PS_WAKE: begin
                if (word_done && word_kind != LP_NONE) state_d = PS_DOWN;
                else if (tmr_expired)                  state_d = PS_READY;
            end
            default:                                         state_d = PS_READY;
        endcase
    end

    // state register plus retained mode and frame classification
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q       <= PS_READY;
            lp_q          <= LP_NONE;
            refen_q       <= 1'b0;
            frame_invalid <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_d == PS_DOWN && state_q != PS_DOWN) begin
                lp_q    <= word_kind;
                refen_q <= word_ref_en;
            end
            if (cs_fall) begin
                frame_invalid <= (state_q != PS_READY);
            end
        end
    end

    // outputs
    always_comb begin
        core_off  = 1'b0;
        ref_off   = 1'b0;
        hold_mode = 1'b0;
        ready     = 1'b0;
        unique case (state_q)
            PS_READY: ready = 1'b1;
            PS_DOWN: begin
                core_off  = 1'b1;
                hold_mode = 1'b1;
                ref_off   = (lp_q == LP_SHUTDOWN) || !refen_q;
            end
            PS_WAKE:  ;
            default:  ;
        endcase
    end

endmodule

// File: rtl/pwrseq_chk.sv
module pwrseq_chk (
    input logic clk,
    input logic rst_n,
    input logic core_off,
    input logic ref_off,
    input logic hold_mode,
    input logic ready
);

    // R6
    hold_with_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_off |-> hold_mode);

    // R4
    ref_needs_core_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_off |-> core_off);

    // R7
    ready_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (!core_off && !hold_mode));

    // R7
    ready_via_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(!core_off && !ready));

    // R7
    wake_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_off) |-> !ready);

endmodule

bind frame_pwr_sequencer pwrseq_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .core_off  (core_off),
    .ref_off   (ref_off),
    .hold_mode (hold_mode),
    .ready     (ready)
);

// File: tb/frame_pwr_sequencer_tb_top.sv
module frame_pwr_sequencer_tb_top;

    localparam int SHDN = 25000;
    localparam int STBY = 38;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sclk = 1'b0;
    logic sdin = 1'b0;
    logic core_off, ref_off, hold_mode, ready, frame_invalid;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    frame_pwr_sequencer #(
        .SHDN_WAKE_CYC (SHDN),
        .STBY_WAKE_CYC (STBY)
    ) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .cs_n          (cs_n),
        .sclk          (sclk),
        .sdin          (sdin),
        .core_off      (core_off),
        .ref_off       (ref_off),
        .hold_mode     (hold_mode),
        .ready         (ready),
        .frame_invalid (frame_invalid)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit q_cs[$], q_sc[$], q_sd[$];
    int m_state;   // 0 ready, 1 down, 2 wake
    int m_kind;    // 0 none, 1 shutdown, 2 standby
    int m_ref;
    int m_cnt, m_bits, m_wait, m_inv;

    always @(posedge clk) begin
        if (!rst_n) begin
            q_cs = '{1'b1, 1'b1, 1'b1};
            q_sc = '{1'b0, 1'b0, 1'b0};
            q_sd = '{1'b0, 1'b0, 1'b0};
            m_state = 0; m_kind = 0; m_ref = 0;
            m_cnt = 0; m_bits = 0; m_wait = 0; m_inv = 0;
        end else begin
            bit cs_now, cs_old, sc_now, sc_old, sd_now, done;
            int code, kind, refb;
            cs_now = q_cs[1]; cs_old = q_cs[2];
            sc_now = q_sc[1]; sc_old = q_sc[2];
            sd_now = q_sd[1];
            done = 1'b0;
            if (!cs_now && cs_old) begin
                m_inv  = (m_state != 0);
                m_cnt  = 0;
                m_bits = 0;
            end else if (sc_now && !sc_old && !cs_now && m_cnt < 15) begin
                m_bits = (m_bits << 1) | int'(sd_now);
                m_cnt++;
                if (m_cnt == 15) done = 1'b1;
            end
            code = (m_bits >> 4) & 3;
            kind = !done ? 0 : (code == 2) ? 1 : (code == 1) ? 2 : 0;
            refb = (m_bits >> 3) & 1;
            case (m_state)
                0: if (kind != 0) begin m_state = 1; m_kind = kind; m_ref = refb; end
                1: if (cs_now && !cs_old) begin
                       m_state = 2;
                       m_wait = (m_kind == 1) ? SHDN - 1 : STBY - 1;
                   end
                default: begin
                    if (kind != 0) begin m_state = 1; m_kind = kind; m_ref = refb; end
                    else if (m_wait == 0) m_state = 0;
                    else m_wait--;
                end
            endcase
            q_cs.push_front(cs_n); void'(q_cs.pop_back());
            q_sc.push_front(sclk); void'(q_sc.pop_back());
            q_sd.push_front(sdin); void'(q_sd.pop_back());
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            int e_core, e_ref;
            e_core = (m_state == 1);
            e_ref  = (m_state == 1) && (m_kind == 1 || m_ref == 0);
            check(core_off == e_core,      "R3 core_off vs model", core_off, e_core);
            check(ref_off == e_ref,        "R4 ref_off vs model", ref_off, e_ref);
            check(hold_mode == e_core,     "R6 hold_mode vs model", hold_mode, e_core);
            check(ready == (m_state == 0), "R7 ready vs model", ready, m_state == 0);
            check(frame_invalid == m_inv,  "R8 frame_invalid vs model", frame_invalid, m_inv);
        end
    end

    // ---------------- stimulus helpers ----------------
    function automatic logic [14:0] mk_word(input logic [1:0] mode, input logic ref_en);
        logic [14:0] w;
        w = 15'h2a01;          // filler in unrelated bits
        w[5:4] = mode;
        w[3]   = ref_en;
        return w;
    endfunction

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(input logic [14:0] w, input int n_edges, input bit lift);
        cs_n = 1'b0;
        waitn(4);
        for (int i = 0; i < n_edges; i++) begin
            sdin = (i < 15) ? w[14 - i] : 1'b1;
            waitn(3);
            sclk = 1'b1;
            waitn(3);
            sclk = 1'b0;
        end
        waitn(4);
        if (lift) begin
            cs_n = 1'b1;
            waitn(6);
        end
    endtask

    // watchdog
    initial begin
        repeat (190000) @(posedge clk);
        check(1'b0, "R7 watchdog expired", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        waitn(5);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(ready == 1'b1,         "R1 ready after reset", ready, 1);
        check(core_off == 1'b0,      "R1 core_off after reset", core_off, 0);
        check(ref_off == 1'b0,       "R1 ref_off after reset", ref_off, 0);
        check(hold_mode == 1'b0,     "R1 hold after reset", hold_mode, 0);
        check(frame_invalid == 1'b0, "R1 invalid after reset", frame_invalid, 0);

        // R5 normal code 00
        send_frame(mk_word(2'b00, 1'b1), 15, 1'b1);
        check(ready == 1'b1 && core_off == 1'b0, "R5 code 00 stays up", core_off, 0);

        // R5 normal code 11
        send_frame(mk_word(2'b11, 1'b0), 15, 1'b1);
        check(core_off == 1'b0, "R5 code 11 stays up", core_off, 0);

        // R2 mode field one position too high: no effect
        send_frame(15'h0040, 15, 1'b1);
        check(core_off == 1'b0, "R2 misplaced field ignored", core_off, 0);

        // R2 aborted frame with shutdown code
        send_frame(mk_word(2'b10, 1'b1), 10, 1'b1);
        check(core_off == 1'b0, "R2 short frame ignored", core_off, 0);

        // R3/R4 standby with reference enabled, 16 edges (extra ignored, R2)
        send_frame(mk_word(2'b01, 1'b1), 16, 1'b0);
        check(core_off == 1'b1,  "R3 standby powers down", core_off, 1);
        check(ready == 1'b0,     "R3 not ready when down", ready, 0);
        check(ref_off == 1'b0,   "R4 standby keeps reference", ref_off, 0);
        check(hold_mode == 1'b1, "R6 hold while down", hold_mode, 1);
        waitn(20);
        check(core_off == 1'b1,  "R6 stays down until cs rises", core_off, 1);
        cs_n = 1'b1;
        waitn(2);
        check(core_off == 1'b1,  "R10 two cycles after cs rise", core_off, 1);
        waitn(1);
        check(core_off == 1'b0,  "R10 third cycle after cs rise", core_off, 0);
        check(hold_mode == 1'b0, "R6 track on wake", hold_mode, 0);
        waitn(STBY - 1);
        check(ready == 1'b0,     "R7 standby wake one short", ready, 0);
        waitn(1);
        check(ready == 1'b1,     "R7 standby wake complete", ready, 1);
        waitn(5);

        // R4 standby with reference disabled
        send_frame(mk_word(2'b01, 1'b0), 15, 1'b0);
        check(ref_off == 1'b1, "R4 standby ref disabled", ref_off, 1);
        cs_n = 1'b1;
        waitn(STBY + 10);

        // R5 normal frame started during standby wake does not stop it
        send_frame(mk_word(2'b01, 1'b1), 15, 1'b1);
        send_frame(mk_word(2'b00, 1'b1), 15, 1'b1);
        check(frame_invalid == 1'b1, "R8 frame during wake flagged", frame_invalid, 1);
        check(ready == 1'b1,         "R5 wake completes under normal frame", ready, 1);

        // R4 shutdown, then R9 re-entry during wake
        send_frame(mk_word(2'b10, 1'b1), 15, 1'b0);
        check(ref_off == 1'b1, "R4 shutdown reference off", ref_off, 1);
        cs_n = 1'b1;
        waitn(10);
        check(core_off == 1'b0 && ready == 1'b0, "R6 shutdown waking", ready, 0);
        send_frame(mk_word(2'b10, 1'b0), 15, 1'b0);
        check(frame_invalid == 1'b1, "R8 early frame invalid", frame_invalid, 1);
        check(core_off == 1'b1,      "R9 down again from wake", core_off, 1);
        cs_n = 1'b1;
        waitn(3);
        waitn(SHDN - 1);
        check(ready == 1'b0, "R7 shutdown wake one short", ready, 0);
        waitn(1);
        check(ready == 1'b1, "R7 shutdown wake complete", ready, 1);
        send_frame(mk_word(2'b00, 1'b0), 15, 1'b1);
        check(frame_invalid == 1'b0, "R8 frame after ready valid", frame_invalid, 0);

        waitn(5);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule